// File: doc/BRIEF.md
# Differential PSK Passband Transmitter

This block turns a serial bit stream into one channel of passband samples ready for a DAC. It runs in one of two modes. In DQPSK mode it takes 2 bits per symbol, and in D8PSK mode it takes 3. Each bit group is Gray decoded into a phase step. The step is added to a running phase index, and that index selects an I/Q point on an 8-point circle. The I value multiplies a sine carrier and the Q value multiplies a cosine carrier. The two products are added, scaled and saturated into a single signed output sample.

Each symbol lasts exactly one carrier period, and a carrier period is 10 samples. The carrier and the symbols therefore stay aligned with no drift. For example, with a 50 MHz carrier the output runs at 500 Msample/s, which carries 100 Mbit/s in DQPSK mode and 150 Mbit/s in D8PSK mode.

Bits enter through a valid/ready handshake. If no complete group is ready at a symbol boundary, the block outputs zeros and keeps its phase until the next group arrives.

Top module: `dpsk_tx`

## Requirements
- R1: `mode_sel` selects the group size: 0 means 2 bits per symbol (DQPSK) and 1 means 3 bits per symbol (D8PSK). The first bit accepted in a group is the group's most significant bit.
- R2: A group value is Gray decoded into a step k, so that a step of k is sent as the code k XOR (k>>1). In D8PSK mode the step is k eighths of a turn. In DQPSK mode it is 2k eighths.
- R3: The phase index counts in eighths of a turn, modulo 8. Each symbol adds its step to the index. The new index is the phase that symbol transmits.
- R4: A phase index p maps to I = round(127·cos(p·45°)) and Q = round(127·sin(p·45°)), both 8-bit signed values.
- R5: For sample n of a symbol (n = 0..9), the carrier values are s(n) = round(127·sin(2πn/10)) and c(n) = round(127·cos(2πn/10)).
- R6: Each output sample equals (I·s(n) + Q·c(n)) arithmetically shifted right by 5. The result is then clamped to the signed 10-bit range −512..511.
- R7: Each symbol produces exactly 10 consecutive samples with `out_valid` high. `out_sym_start` is high on sample 0 only. If bits keep up, symbols follow each other with no gap.
- R8: If no complete group is ready at a symbol boundary, `out_valid` is low and `out_sample` is 0. The phase index is held until the next symbol.
- R9: Once a group is complete, `bit_ready` stays low until that group is taken at a symbol boundary.
- R10: The mode is sampled with the first bit of each group. Changing `mode_sel` partway through a group does not change that group's size or mode.
- R11: A synchronous reset sets the phase index to 0, discards any partial group, sets the outputs to 0 with `out_valid` low, and raises `bit_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = DQPSK (2 bits per symbol), 1 = D8PSK (3 bits per symbol) |
| bit_valid | input | 1 | Serial bit is present |
| bit_data | input | 1 | Serial bit value |
| bit_ready | output | 1 | Block accepts a bit this cycle |
| out_sample | output | 10 | Signed passband sample for the DAC |
| out_valid | output | 1 | Sample belongs to a transmitted symbol |
| out_sym_start | output | 1 | Sample is the first of a symbol |

## Verification
A wrong phase index is never seen directly. It shows up as a rotated sine wave across all 10 samples of the next symbol, so the scoreboard catches it within one symbol period. Since the encoding is differential, the error then carries into every later symbol. A grouping fault, such as a lost bit or a wrong group size, shifts every group that follows. It is therefore detected within a few symbols. A framing fault, such as a wrong symbol length or a start marker in the wrong place, shows within 10 samples through the start flag and the idle-zero check.

// File: rtl/dpsk_tx_pkg.sv
package dpsk_tx_pkg;

  localparam int unsigned SPS_DEFAULT = 10;
  localparam int unsigned TBL_W       = 8;
  localparam int unsigned GRP_MAX     = 3;
  localparam int unsigned GRP_CNT_W   = 2;
  localparam int unsigned PH_W        = 3;

  typedef struct packed {
    logic               wide;
    logic [GRP_MAX-1:0] bits;
  } group_t;

  // Phase index -> in-phase amplitude, 45 degrees per step
  function automatic logic signed [TBL_W-1:0] pt_cos(input logic [PH_W-1:0] p);
    case (p)
      3'd0:    return  8'sd127;
      3'd1:    return  8'sd90;
      3'd2:    return  8'sd0;
      3'd3:    return -8'sd90;
      3'd4:    return -8'sd127;
      3'd5:    return -8'sd90;
      3'd6:    return  8'sd0;
      default: return  8'sd90;
    endcase
  endfunction

  function automatic logic signed [TBL_W-1:0] pt_sin(input logic [PH_W-1:0] p);
    return pt_cos(p - 3'd2);
  endfunction

  // Carrier tables, ten samples per period
  function automatic logic signed [TBL_W-1:0] car_sin(input logic [3:0] n);
    case (n)
      4'd0:    return  8'sd0;
      4'd1:    return  8'sd75;
      4'd2:    return  8'sd121;
      4'd3:    return  8'sd121;
      4'd4:    return  8'sd75;
      4'd5:    return  8'sd0;
      4'd6:    return -8'sd75;
      4'd7:    return -8'sd121;
      4'd8:    return -8'sd121;
      default: return -8'sd75;
    endcase
  endfunction

  function automatic logic signed [TBL_W-1:0] car_cos(input logic [3:0] n);
    case (n)
      4'd0:    return  8'sd127;
      4'd1:    return  8'sd103;
      4'd2:    return  8'sd39;
      4'd3:    return -8'sd39;
      4'd4:    return -8'sd103;
      4'd5:    return -8'sd127;
      4'd6:    return -8'sd103;
      4'd7:    return -8'sd39;
      4'd8:    return  8'sd39;
      default: return  8'sd103;
    endcase
  endfunction

  // Gray decode of a bit group into a phase step in eighths of a turn
  function automatic logic [PH_W-1:0] gray_step(input group_t g);
    logic b2, b1, b0;
    b2 = g.bits[2];
    b1 = g.bits[1];
    b0 = g.bits[0];
    if (g.wide) return {b2, b2 ^ b1, b2 ^ b1 ^ b0};
    else        return {b1, b1 ^ b0, 1'b0};
  endfunction

endpackage

// File: rtl/dpsk_bit_grouper.sv
module dpsk_bit_grouper
  import dpsk_tx_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   mode_i,
  input  logic   bit_valid_i,
  input  logic   bit_data_i,
  input  logic   take_i,
  output logic   bit_ready_o,
  output logic   grp_full_o,
  output group_t grp_o
);

  logic [GRP_CNT_W-1:0] cnt_q;
  logic [GRP_MAX-1:0]   shreg_q;
  logic                 wide_q;
  logic                 full_q;
  logic                 eff_wide;
  logic [GRP_CNT_W-1:0] need;
  logic                 accept;

  // Mode is captured with the first bit of a group and held after that
  assign eff_wide    = (cnt_q == '0) ? mode_i : wide_q;
  assign need        = eff_wide ? GRP_CNT_W'(3) : GRP_CNT_W'(2);
  assign bit_ready_o = !full_q;
  assign accept      = bit_valid_i && !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      shreg_q <= '0;
      wide_q  <= 1'b0;
      full_q  <= 1'b0;
    end else if (take_i) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (accept) begin
      cnt_q  <= cnt_q + 1'b1;
      wide_q <= eff_wide;
      if (cnt_q == '0) shreg_q <= {{(GRP_MAX-1){1'b0}}, bit_data_i};
      else             shreg_q <= {shreg_q[GRP_MAX-2:0], bit_data_i};
      if (GRP_CNT_W'(cnt_q + 1'b1) == need) full_q <= 1'b1;
    end
  end

  assign grp_full_o = full_q;
  assign grp_o      = '{wide: wide_q, bits: shreg_q};

endmodule

// File: rtl/dpsk_symbol_seq.sv
module dpsk_symbol_seq
  import dpsk_tx_pkg::*;
#(
  parameter int unsigned SPS   = SPS_DEFAULT,
  parameter int unsigned IDX_W = $clog2(SPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grp_full_i,
  input  group_t           grp_i,
  output logic             take_o,
  output logic             busy_o,
  output logic             first_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [PH_W-1:0]  phase_o
);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [PH_W-1:0]  phase_q;
  logic             boundary;

  assign boundary = !busy_q || (idx_q == IDX_W'(SPS - 1));
  assign take_o   = boundary && grp_full_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      phase_q <= '0;
    end else if (boundary) begin
      idx_q  <= '0;
      busy_q <= grp_full_i;
      if (grp_full_i) phase_q <= phase_q + gray_step(grp_i);
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign first_o = busy_q && (idx_q == '0);
  assign idx_o   = idx_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/dpsk_iq_mixer.sv
module dpsk_iq_mixer
  import dpsk_tx_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OUT_W = 10,
  parameter int unsigned SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_i,
  input  logic             first_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PH_W-1:0]  phase_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o,
  output logic             start_o
);

  localparam int unsigned SUM_W = 2 * TBL_W + 1;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -SUM_W'(1 << (OUT_W - 1));

  logic signed [TBL_W-1:0] i_v, q_v, s_v, c_v;
  logic signed [SUM_W-1:0] sum, scaled;
  logic        [OUT_W-1:0] sat;

  assign i_v = pt_cos(phase_i);
  assign q_v = pt_sin(phase_i);
  assign s_v = car_sin(4'(idx_i));
  assign c_v = car_cos(4'(idx_i));

  assign sum    = i_v * s_v + q_v * c_v;
  assign scaled = sum >>> SHIFT;

  always_comb begin
    if (scaled > MAXV)      sat = MAXV[OUT_W-1:0];
    else if (scaled < MINV) sat = MINV[OUT_W-1:0];
    else                    sat = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
      start_o  <= 1'b0;
    end else begin
      sample_o <= busy_i ? sat : '0;
      valid_o  <= busy_i;
      start_o  <= first_i;
    end
  end

endmodule

// File: rtl/dpsk_tx.sv
module dpsk_tx
  import dpsk_tx_pkg::*;
#(
  parameter int unsigned SAMPLES_PER_SYM = SPS_DEFAULT,
  parameter int unsigned OUT_W           = 10,
  parameter int unsigned SHIFT           = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             bit_ready,
  output logic [OUT_W-1:0] out_sample,
  output logic             out_valid,
  output logic             out_sym_start
);

  localparam int unsigned IDX_W = $clog2(SAMPLES_PER_SYM);

  group_t           grp;
  logic             grp_full;
  logic             sym_take;
  logic             busy;
  logic             first;
  logic [IDX_W-1:0] idx;
  logic [PH_W-1:0]  phase_idx;

  dpsk_bit_grouper u_grp (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_sel),
    .bit_valid_i(bit_valid),
    .bit_data_i (bit_data),
    .take_i     (sym_take),
    .bit_ready_o(bit_ready),
    .grp_full_o (grp_full),
    .grp_o      (grp)
  );

  dpsk_symbol_seq #(.SPS(SAMPLES_PER_SYM), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .grp_full_i(grp_full),
    .grp_i     (grp),
    .take_o    (sym_take),
    .busy_o    (busy),
    .first_o   (first),
    .idx_o     (idx),
    .phase_o   (phase_idx)
  );

  dpsk_iq_mixer #(.IDX_W(IDX_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_mix (
    .clk     (clk),
    .rst     (rst),
    .busy_i  (busy),
    .first_i (first),
    .idx_i   (idx),
    .phase_i (phase_idx),
    .sample_o(out_sample),
    .valid_o (out_valid),
    .start_o (out_sym_start)
  );

endmodule

// File: rtl/dpsk_tx_chk.sv
module dpsk_tx_chk #(
  parameter int unsigned SPS   = 10,
  parameter int unsigned OUT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_ready,
  input logic [OUT_W-1:0] out_sample,
  input logic             out_valid,
  input logic             out_sym_start,
  input logic             sym_take,
  input logic [2:0]       phase_idx
);

  localparam int unsigned CNT_W = $clog2(SPS + 1) + 1;

  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst)                seen <= '0;
    else if (out_sym_start) seen <= CNT_W'(1);
    else if (out_valid)     seen <= seen + 1'b1;
    else                    seen <= '0;
  end

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_sample == '0));

  // R7
  start_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_sym_start |-> out_valid);

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_sym_start);

  // R7
  sym_body_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sym_start) |-> (seen < CNT_W'(SPS)));

  // R7
  sym_len_chk: assert property (@(posedge clk) disable iff (rst)
    (out_sym_start && $past(out_valid)) |-> (seen == CNT_W'(SPS)));

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sym_take |=> $stable(phase_idx));

  // R9
  ready_full_chk: assert property (@(posedge clk) disable iff (rst)
    sym_take |-> !bit_ready);

endmodule

bind dpsk_tx dpsk_tx_chk #(.SPS(SAMPLES_PER_SYM), .OUT_W(OUT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bit_ready    (bit_ready),
  .out_sample   (out_sample),
  .out_valid    (out_valid),
  .out_sym_start(out_sym_start),
  .sym_take     (sym_take),
  .phase_idx    (phase_idx)
);

// File: tb/dpsk_tx_tb.sv
module dpsk_tx_tb;

  localparam int SPS = 10;
  localparam real PI = 3.14159265358979323846;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_sel = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b0;
  logic       bit_ready;
  logic [9:0] out_sample;
  logic       out_valid;
  logic       out_sym_start;

  int checks = 0;
  int errors = 0;
  int ph_model = 0;
  int cycles = 0;

  int    exp_q[$];
  bit    first_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  dpsk_tx u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .out_sample(out_sample), .out_valid(out_valid), .out_sym_start(out_sym_start)
  );

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int model_sample(input int ph, input int n);
    int iv, qv, sv, cv, v;
    iv = rnd(127.0 * $cos(ph * PI / 4.0));
    qv = rnd(127.0 * $sin(ph * PI / 4.0));
    sv = rnd(127.0 * $sin(2.0 * PI * n / SPS));
    cv = rnd(127.0 * $cos(2.0 * PI * n / SPS));
    v  = (iv * sv + qv * cv) >>> 5;
    if (v > 511)  v = 511;
    if (v < -512) v = -512;
    return v;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Driver: pushes expected samples, then serialises the group MSB first
  task automatic send_symbol(input bit wide, input int code, input string tag,
                             input bit flip_mode = 1'b0, input bit expect_stall = 1'b0);
    int nb, step;
    nb = wide ? 3 : 2;
    step = 0;
    for (int k = 0; k < (1 << nb); k++)
      if ((k ^ (k >> 1)) == code) step = k;
    ph_model = (ph_model + (wide ? step : 2 * step)) % 8;
    for (int n = 0; n < SPS; n++) begin
      exp_q.push_back(model_sample(ph_model, n));
      first_q.push_back(n == 0);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      mode_sel  = (flip_mode && i > 0) ? !wide : wide;
      bit_valid = 1'b1;
      bit_data  = code[nb-1-i];
      while (!bit_ready) @(negedge clk);
      @(posedge clk);
      #1 bit_valid = 1'b0;
    end
    if (expect_stall) begin
      @(negedge clk);
      check(bit_ready == 1'b0, "R9 ready low while group waits", int'(bit_ready), 0);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compares every output sample against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected valid sample", $signed(out_sample), 0);
        end else begin
          int e;
          bit f;
          string t;
          e = exp_q.pop_front();
          f = first_q.pop_front();
          t = tag_q.pop_front();
          check($signed(out_sample) == e, {t, "/R6 sample value"}, $signed(out_sample), e);
          check(out_sym_start == f, "R7 symbol start flag", int'(out_sym_start), int'(f));
        end
      end else begin
        check(out_sample == '0, "R8 idle sample", $signed(out_sample), 0);
        check(out_sym_start == 1'b0, "R8 idle start flag", int'(out_sym_start), 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lfsr;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(bit_ready == 1'b1, "R11 ready after reset", int'(bit_ready), 1);
    check(out_valid == 1'b0, "R11 valid after reset", int'(out_valid), 0);
    check(out_sample == '0, "R11 sample after reset", $signed(out_sample), 0);

    // R5 phase 0 carrier shape
    send_symbol(1'b1, 0, "R5");
    // R2 every 8-PSK code
    for (int c = 0; c < 8; c++) send_symbol(1'b1, c, "R2");
    // R4 walk all eight phases
    for (int c = 0; c < 8; c++) send_symbol(1'b1, 1, "R4");
    // R3 every QPSK code, twice
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 4; c++) send_symbol(1'b0, c, "R3");
    // R1 alternating modes
    for (int c = 0; c < 6; c++) send_symbol(c[0], (c * 3) % (c[0] ? 8 : 4), "R1");
    drain();

    // R8 stall: zeros, then phase continues
    repeat (25) @(negedge clk);
    send_symbol(1'b1, 5, "R8");
    drain();

    // R9 second group waits while first symbol plays
    send_symbol(1'b0, 2, "R9");
    send_symbol(1'b0, 3, "R9", 1'b0, 1'b1);
    drain();

    // R10 mode flips mid-group
    send_symbol(1'b0, 1, "R10", 1'b1);
    send_symbol(1'b1, 6, "R10", 1'b1);
    send_symbol(1'b0, 3, "R10", 1'b1);
    drain();

    // R11 reset discards partial group and phase
    @(negedge clk);
    mode_sel = 1'b1; bit_valid = 1'b1; bit_data = 1'b1;
    @(posedge clk);
    #1 bit_valid = 1'b0; rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    ph_model = 0;
    @(negedge clk);
    check(bit_ready == 1'b1, "R11 ready after mid-run reset", int'(bit_ready), 1);
    check(out_valid == 1'b0, "R11 valid after mid-run reset", int'(out_valid), 0);
    send_symbol(1'b1, 3, "R11");
    send_symbol(1'b0, 1, "R11");
    drain();

    // R6 long pseudo-random stream
    lfsr = 32'h1d;
    for (int s = 0; s < 60; s++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 255;
      send_symbol(lfsr[6], lfsr[6] ? (lfsr & 7) : (lfsr & 3), "R6");
    end
    drain();
    check(exp_q.size() == 0, "R7 scoreboard empty", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule